// File: doc/BRIEF.md
# Start-Stop Serial Receiver with Flag-Bit Frame Filtering

This block receives asynchronous start-stop frames from a single serial line. A baud generator outside the block supplies a tick at sixteen times the bit rate. The line is synchronized, and a frame opens on a falling edge. The start bit is confirmed at its midpoint. Then 7 or 8 data bits are taken least significant bit first. An optional extra bit comes next: an even or odd parity bit, or a flag bit that is compared with a configured value. Last comes one stop bit.

A completed frame is moved into a receive buffer and sets a buffer-full flag. Three sticky error flags record overrun, framing and parity faults. Two gated interrupt requests, one for receive and one for errors, are built from these flags.

In flag mode, a frame whose flag bit disagrees with the configured value is dropped without a trace. The buffer, the buffer-full flag and the overrun flag are left as they were. This lets a receiver on a shared line ignore frames that are not meant for it. A software side reads the buffer and the flags directly. It releases them with one-cycle clear pulses, which stand for writing zero to each flag.

Top module: `serial_frame_rx`

## Requirements
- R1: A frame is accepted only while rxEnable is 1 and modeConflict is 0. If either condition fails, the receiver drops back to idle and bufFull cannot rise in the following cycle.
- R2: Reception opens on a 1-to-0 transition of the synchronized line. If the line reads 1 at the start bit's midpoint, eight ticks later, the attempt is dropped and the receiver waits for the next falling edge.
- R3: When shortWord is 0, eight data bits are received, LSB first. When shortWord is 1, seven bits are received and rxBuffer[7] is 0.
- R4: With flagMode at 0, a parityMode of 2'b10 adds an even parity bit and 2'b11 adds an odd parity bit. Values 2'b00 and 2'b01 add no extra bit. A parity bit that does not match the received data sets the sticky parityErr flag.
- R5: With flagMode at 1 and parityMode at 2'b00, one flag bit follows the data. If it differs from flagValue, the frame is discarded: rxBuffer, bufFull and overrunErr keep their values.
- R6: Only the first stop bit is sampled, even when twoStop is 1. A 0 in that bit sets the sticky framingErr flag, and the data is still delivered.
- R7: An accepted frame is copied into rxBuffer and sets bufFull to 1.
- R8: A frame that completes while bufFull is 1 sets overrunErr and leaves rxBuffer unchanged. A clrFull pulse in the completion cycle counts as an empty buffer, so the frame is loaded and no overrun is recorded.
- R9: rxIrq is 1 exactly when bufFull, irqRxEn and irqGlobalEn are all 1.
- R10: errIrq is 1 exactly when at least one error flag is set and both irqErrEn and irqGlobalEn are 1.
- R11: Each clear input zeroes its flag on the next edge. If the flag is set in that same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Oversampling tick, 16 per bit |
| serialIn | input | 1 | Asynchronous serial line, idles high |
| rxEnable | input | 1 | Receive enable |
| modeConflict | input | 1 | Competing serial mode selected; blocks reception |
| shortWord | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| parityMode | input | 2 | 10 even, 11 odd, 00/01 none |
| flagMode | input | 1 | Flag-bit filtering enable |
| flagValue | input | 1 | Expected flag bit |
| twoStop | input | 1 | Two-stop-bit setting, ignored by the receiver |
| irqRxEn | input | 1 | Receive interrupt enable |
| irqErrEn | input | 1 | Error interrupt enable |
| irqGlobalEn | input | 1 | Global serial interrupt enable |
| clrFull | input | 1 | Pulse: clear bufFull |
| clrOverrun | input | 1 | Pulse: clear overrunErr |
| clrFraming | input | 1 | Pulse: clear framingErr |
| clrParity | input | 1 | Pulse: clear parityErr |
| rxBuffer | output | 8 | Receive buffer |
| bufFull | output | 1 | Buffer holds unread data |
| overrunErr | output | 1 | Sticky overrun flag |
| framingErr | output | 1 | Sticky framing flag |
| parityErr | output | 1 | Sticky parity flag |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Error interrupt request |

## Verification
The collision of interest is frame completion meeting a clrFull pulse while the buffer is still full. The bench preloads the buffer with one frame, then sends a second frame. It slides a single-cycle clrFull pulse across offsets 6 to 14 clocks into the stop bit. For pulses up to and including the completion cycle at offset 10, the second frame must be loaded, bufFull must read 1 and overrunErr must read 0. For later pulses, the first frame must be kept, overrunErr must be set and bufFull must read 0.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic shiftBit;   // capture a data bit into the shift register
    logic takeExtra;  // capture the parity or flag bit
    logic endFrame;   // stop bit sampled, finish the frame
  } rxStrobes_t;

  localparam logic [1:0] PAR_EVEN = 2'b10;
  localparam logic [1:0] PAR_ODD  = 2'b11;
  localparam logic [1:0] PAR_NONE = 2'b00;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       lineNow,
  input  logic       linePrev,
  input  logic       enabled,
  input  logic       shortWord,
  input  logic       flagMode,
  input  logic [1:0] parityMode,
  output rxStrobes_t strobes
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] MID_PHASE  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(OVERSAMPLE - 1);

  rxState_t         state;
  logic [CNT_W-1:0] phase;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] dataBits;
  logic [IDX_W-1:0] frameBits;
  logic             hasExtra;
  logic             atMid;
  logic             atEnd;

  always_comb begin
    hasExtra  = (!flagMode && parityMode[1]) || (flagMode && parityMode == PAR_NONE);
    dataBits  = shortWord ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W);
    frameBits = dataBits + IDX_W'(hasExtra);
    atMid     = sampleTick && (phase == MID_PHASE);
    atEnd     = sampleTick && (phase == LAST_PHASE);
  end

  always_comb begin
    strobes = '0;
    if (enabled) begin
      if (state == RX_BITS && atEnd) begin
        if (bitIdx < dataBits) strobes.shiftBit  = 1'b1;
        else                   strobes.takeExtra = 1'b1;
      end
      if (state == RX_STOP && atEnd) strobes.endFrame = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (!enabled) begin
      state  <= RX_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else begin
      if (sampleTick) phase <= atEnd ? '0 : phase + 1'b1;
      case (state)
        RX_IDLE: begin
          phase  <= '0;
          bitIdx <= '0;
          if (linePrev && !lineNow) state <= RX_START;
        end
        RX_START: begin
          if (atMid) begin
            phase <= '0;
            state <= lineNow ? RX_IDLE : RX_BITS;
          end
        end
        RX_BITS: begin
          if (atEnd) begin
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == frameBits - 1'b1) state <= RX_STOP;
          end
        end
        default: begin
          if (atEnd) state <= RX_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  rxStrobes_t        strobes,
  input  logic              shortWord,
  input  logic              flagMode,
  input  logic [1:0]        parityMode,
  input  logic              flagValue,
  input  logic              clrFull,
  input  logic              clrOverrun,
  input  logic              clrFraming,
  input  logic              clrParity,
  output logic              lineNow,
  output logic              linePrev,
  output logic [DATA_W-1:0] rxBuffer,
  output logic              bufFull,
  output logic              overrunErr,
  output logic              framingErr,
  output logic              parityErr
);
  logic              syncA;
  logic [DATA_W-1:0] shiftReg;
  logic              extraBit;
  logic [DATA_W-1:0] word;
  logic              parActive;
  logic              flagActive;
  logic              parBad;
  logic              flagBad;
  logic              fullEff;
  logic              doLoad;
  logic              doOverrun;
  logic              doFraming;
  logic              doParity;

  always_comb begin
    word       = shortWord ? {1'b0, shiftReg[DATA_W-1:1]} : shiftReg;
    parActive  = !flagMode && parityMode[1];
    flagActive = flagMode && (parityMode == PAR_NONE);
    parBad     = parActive && ((^word ^ extraBit) != parityMode[0]);
    flagBad    = flagActive && (extraBit != flagValue);
    fullEff    = bufFull && !clrFull;
    doLoad     = strobes.endFrame && !flagBad && !fullEff;
    doOverrun  = strobes.endFrame && !flagBad && fullEff;
    doFraming  = strobes.endFrame && !lineNow;
    doParity   = strobes.endFrame && parBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA      <= 1'b1;
      lineNow    <= 1'b1;
      linePrev   <= 1'b1;
      shiftReg   <= '0;
      extraBit   <= 1'b0;
      rxBuffer   <= '0;
      bufFull    <= 1'b0;
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
      parityErr  <= 1'b0;
    end else begin
      syncA    <= serialIn;
      lineNow  <= syncA;
      linePrev <= lineNow;
      if (strobes.shiftBit)  shiftReg <= {lineNow, shiftReg[DATA_W-1:1]};
      if (strobes.takeExtra) extraBit <= lineNow;
      if (doLoad) rxBuffer <= word;
      bufFull    <= doLoad    ? 1'b1 : (clrFull    ? 1'b0 : bufFull);
      overrunErr <= doOverrun ? 1'b1 : (clrOverrun ? 1'b0 : overrunErr);
      framingErr <= doFraming ? 1'b1 : (clrFraming ? 1'b0 : framingErr);
      parityErr  <= doParity  ? 1'b1 : (clrParity  ? 1'b0 : parityErr);
    end
  end

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              serialIn,
  input  logic              rxEnable,
  input  logic              modeConflict,
  input  logic              shortWord,
  input  logic [1:0]        parityMode,
  input  logic              flagMode,
  input  logic              flagValue,
  input  logic              twoStop,
  input  logic              irqRxEn,
  input  logic              irqErrEn,
  input  logic              irqGlobalEn,
  input  logic              clrFull,
  input  logic              clrOverrun,
  input  logic              clrFraming,
  input  logic              clrParity,
  output logic [DATA_W-1:0] rxBuffer,
  output logic              bufFull,
  output logic              overrunErr,
  output logic              framingErr,
  output logic              parityErr,
  output logic              rxIrq,
  output logic              errIrq
);
  rxStrobes_t strobes;
  logic       lineNow;
  logic       linePrev;
  logic       enabled;
  logic       stopSettingUnused;

  assign enabled           = rxEnable && !modeConflict;
  assign stopSettingUnused = twoStop;  // receiver samples only the first stop bit

  serial_rx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .lineNow    (lineNow),
    .linePrev   (linePrev),
    .enabled    (enabled),
    .shortWord  (shortWord),
    .flagMode   (flagMode),
    .parityMode (parityMode),
    .strobes    (strobes)
  );

  serial_rx_datapath #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .strobes    (strobes),
    .shortWord  (shortWord),
    .flagMode   (flagMode),
    .parityMode (parityMode),
    .flagValue  (flagValue),
    .clrFull    (clrFull),
    .clrOverrun (clrOverrun),
    .clrFraming (clrFraming),
    .clrParity  (clrParity),
    .lineNow    (lineNow),
    .linePrev   (linePrev),
    .rxBuffer   (rxBuffer),
    .bufFull    (bufFull),
    .overrunErr (overrunErr),
    .framingErr (framingErr),
    .parityErr  (parityErr)
  );

  assign rxIrq  = bufFull && irqRxEn && irqGlobalEn;
  assign errIrq = (overrunErr || framingErr || parityErr) && irqErrEn && irqGlobalEn;

endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              modeConflict,
  input logic              clrFull,
  input logic              clrOverrun,
  input logic              clrFraming,
  input logic              clrParity,
  input logic [DATA_W-1:0] rxBuffer,
  input logic              bufFull,
  input logic              overrunErr,
  input logic              framingErr,
  input logic              parityErr,
  input logic              rxIrq,
  input logic              errIrq
);
  AST_OFF_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable || modeConflict) |=> !$rose(bufFull)); // R1
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxBuffer) |-> bufFull); // R7
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !clrFull) |=> $stable(rxBuffer)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && !clrOverrun) |=> overrunErr); // R8
  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (framingErr && !clrFraming) |=> framingErr); // R6
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !clrParity) |=> parityErr); // R4
  AST_RXIRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> bufFull); // R9
  AST_ERRIRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> (overrunErr || framingErr || parityErr)); // R10
endmodule

bind serial_frame_rx serial_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rxEnable     (rxEnable),
  .modeConflict (modeConflict),
  .clrFull      (clrFull),
  .clrOverrun   (clrOverrun),
  .clrFraming   (clrFraming),
  .clrParity    (clrParity),
  .rxBuffer     (rxBuffer),
  .bufFull      (bufFull),
  .overrunErr   (overrunErr),
  .framingErr   (framingErr),
  .parityErr    (parityErr),
  .rxIrq        (rxIrq),
  .errIrq       (errIrq)
);

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b1;
  logic       serialIn = 1'b1;
  logic       rxEnable = 1'b1, modeConflict = 1'b0, shortWord = 1'b0;
  logic [1:0] parityMode = 2'b00;
  logic       flagMode = 1'b0, flagValue = 1'b0, twoStop = 1'b0;
  logic       irqRxEn = 1'b0, irqErrEn = 1'b0, irqGlobalEn = 1'b0;
  logic       clrFull = 1'b0, clrOverrun = 1'b0, clrFraming = 1'b0, clrParity = 1'b0;
  logic [7:0] rxBuffer;
  logic       bufFull, overrunErr, framingErr, parityErr, rxIrq, errIrq;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  serial_frame_rx u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .serialIn(serialIn),
    .rxEnable(rxEnable), .modeConflict(modeConflict), .shortWord(shortWord),
    .parityMode(parityMode), .flagMode(flagMode), .flagValue(flagValue),
    .twoStop(twoStop), .irqRxEn(irqRxEn), .irqErrEn(irqErrEn),
    .irqGlobalEn(irqGlobalEn), .clrFull(clrFull), .clrOverrun(clrOverrun),
    .clrFraming(clrFraming), .clrParity(clrParity), .rxBuffer(rxBuffer),
    .bufFull(bufFull), .overrunErr(overrunErr), .framingErr(framingErr),
    .parityErr(parityErr), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    serialIn = v;
    repeat (16) @(negedge clk);
  endtask

  // start bit, nData bits LSB first, optional extra bit, one stop bit;
  // clrFull pulses for one cycle at offset pulseAt into the stop bit
  task automatic send_frame(input logic [7:0] d, input int nData, input int nExtra,
                            input logic ex, input logic stopV, input int pulseAt,
                            input int idleAfter);
    hold_bit(1'b0);
    for (int i = 0; i < nData; i++) hold_bit(d[i]);
    if (nExtra > 0) hold_bit(ex);
    serialIn = stopV;
    for (int o = 0; o < 16; o++) begin
      clrFull = (o == pulseAt);
      @(negedge clk);
    end
    clrFull = 1'b0;
    serialIn = 1'b1;
    repeat (idleAfter) @(negedge clk);
  endtask

  task automatic clear_all();
    clrFull = 1'b1; clrOverrun = 1'b1; clrFraming = 1'b1; clrParity = 1'b1;
    @(negedge clk);
    clrFull = 1'b0; clrOverrun = 1'b0; clrFraming = 1'b0; clrParity = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] prevBuf;
    prevBuf = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expect_eq("R7", "reset bufFull", int'(bufFull), 0);
    expect_eq("R7", "reset rxBuffer", int'(rxBuffer), 0);
    expect_eq("R11", "reset error flags", int'({overrunErr, framingErr, parityErr}), 0);
    expect_eq("R9", "reset rxIrq", int'(rxIrq), 0);

    // Sweep of word length, extra-bit modes and data patterns (R3 R4 R5 R6 R7)
    for (int sw = 0; sw < 2; sw++) begin
      for (int cfg = 0; cfg < 5; cfg++) begin
        for (int k = 0; k < 6; k++) begin
          logic [7:0] mask, d, expBuf;
          logic ex;
          int nExtra;
          bit drop, expPar;
          mask = sw ? 8'h7f : 8'hff;
          d = 8'(k * 73 + cfg * 29 + sw * 11) & mask;
          shortWord = sw[0];
          twoStop = k[1];
          flagMode = (cfg == 3);
          parityMode = (cfg == 1) ? 2'b10 : (cfg == 2) ? 2'b11 : (cfg == 4) ? 2'b01 : 2'b00;
          flagValue = k[0];
          nExtra = (cfg >= 1 && cfg <= 3) ? 1 : 0;
          ex = 1'b0;
          if (cfg == 1) ex = (^d) ^ (k == 3);
          if (cfg == 2) ex = (~^d) ^ (k == 3);
          if (cfg == 3) ex = (k == 4) ? ~flagValue : flagValue;
          drop = (cfg == 3) && (k == 4);
          expPar = (cfg == 1 || cfg == 2) && (k == 3);
          expBuf = drop ? prevBuf : d;
          send_frame(d, sw ? 7 : 8, nExtra, ex, 1'b1, -1, 4);
          expect_eq(drop ? "R5" : "R3", "rxBuffer", int'(rxBuffer), int'(expBuf));
          expect_eq(drop ? "R5" : "R7", "bufFull", int'(bufFull), drop ? 0 : 1);
          expect_eq("R4", "parityErr", int'(parityErr), int'(expPar));
          expect_eq("R6", "framingErr", int'(framingErr), 0);
          expect_eq(drop ? "R5" : "R8", "overrunErr", int'(overrunErr), 0);
          prevBuf = expBuf;
          clear_all();
        end
      end
    end

    // R6: zero stop bit flags framing, data still delivered
    shortWord = 1'b0; flagMode = 1'b0; parityMode = 2'b00; twoStop = 1'b1;
    send_frame(8'hA5, 8, 0, 1'b0, 1'b0, -1, 4);
    expect_eq("R6", "framingErr on zero stop", int'(framingErr), 1);
    expect_eq("R6", "data with framing fault", int'(rxBuffer), 8'hA5);

    // R9 R10: interrupt gating over all enable combinations (bufFull=1, framing=1)
    for (int e = 0; e < 8; e++) begin
      irqRxEn = e[0]; irqErrEn = e[1]; irqGlobalEn = e[2];
      @(negedge clk);
      expect_eq("R9", "rxIrq gating", int'(rxIrq), (e[0] && e[2]) ? 1 : 0);
      expect_eq("R10", "errIrq gating", int'(errIrq), (e[1] && e[2]) ? 1 : 0);
    end
    clrFraming = 1'b1;
    @(negedge clk);
    clrFraming = 1'b0;
    @(negedge clk);
    expect_eq("R10", "errIrq after flags cleared", int'(errIrq), 0);
    expect_eq("R11", "framingErr cleared", int'(framingErr), 0);
    expect_eq("R9", "rxIrq still up", int'(rxIrq), 1);
    clear_all();
    expect_eq("R9", "rxIrq after clrFull", int'(rxIrq), 0);
    irqRxEn = 1'b0; irqErrEn = 1'b0; irqGlobalEn = 1'b0;

    // R6: twoStop set, next frame starts right after the first stop bit
    send_frame(8'h3C, 8, 0, 1'b0, 1'b1, -1, 0);
    clear_all();
    send_frame(8'hC3, 8, 0, 1'b0, 1'b1, -1, 4);
    expect_eq("R6", "back-to-back with twoStop framing", int'(framingErr), 0);
    expect_eq("R6", "back-to-back with twoStop data", int'(rxBuffer), 8'hC3);
    clear_all();
    twoStop = 1'b0;

    // R8: overrun keeps first frame
    send_frame(8'h11, 8, 0, 1'b0, 1'b1, -1, 4);
    send_frame(8'h22, 8, 0, 1'b0, 1'b1, -1, 4);
    expect_eq("R8", "overrunErr", int'(overrunErr), 1);
    expect_eq("R8", "buffer kept on overrun", int'(rxBuffer), 8'h11);
    clear_all();

    // R2: short low glitch is not a start bit
    serialIn = 1'b0;
    repeat (3) @(negedge clk);
    serialIn = 1'b1;
    repeat (30) @(negedge clk);
    expect_eq("R2", "glitch ignored", int'(bufFull), 0);
    send_frame(8'h5A, 8, 0, 1'b0, 1'b1, -1, 4);
    expect_eq("R2", "frame after glitch", int'(rxBuffer), 8'h5A);
    clear_all();

    // R1: disabled receiver and conflicting mode
    rxEnable = 1'b0;
    send_frame(8'h77, 8, 0, 1'b0, 1'b1, -1, 4);
    expect_eq("R1", "no load while disabled", int'(bufFull), 0);
    rxEnable = 1'b1; modeConflict = 1'b1;
    send_frame(8'h66, 8, 0, 1'b0, 1'b1, -1, 4);
    expect_eq("R1", "no load in conflicting mode", int'(bufFull), 0);
    expect_eq("R1", "buffer untouched", int'(rxBuffer), 8'h5A);
    modeConflict = 1'b0;

    // R8 R11: clrFull pulse swept across the completion cycle (offset 10)
    for (int o = 6; o < 15; o++) begin
      logic [7:0] a, b;
      a = 8'(8'h40 + o);
      b = 8'(8'h90 + o);
      clear_all();
      send_frame(a, 8, 0, 1'b0, 1'b1, -1, 4);
      send_frame(b, 8, 0, 1'b0, 1'b1, o, 4);
      if (o <= 10) begin
        expect_eq("R8", "collision load", int'(rxBuffer), int'(b));
        expect_eq("R11", "collision bufFull", int'(bufFull), 1);
        expect_eq("R8", "collision no overrun", int'(overrunErr), 0);
      end else begin
        expect_eq("R8", "late clear keeps old", int'(rxBuffer), int'(a));
        expect_eq("R11", "late clear bufFull", int'(bufFull), 0);
        expect_eq("R8", "late clear overrun", int'(overrunErr), 1);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule